// File: doc/BRIEF.md
# Packet Octet Window Extractor

This block serves 32-bit operand words out of a packet whose octets are still streaming in, one per clock at most. A requester names a start position as one of five base points plus a 5-bit octet offset, together with a 5-bit length code. The block assembles the four octets that begin at that position, keeps only the low (code+1) bits, and says in the same cycle whether the word can be used. If it cannot, the block also gives the reason. Either some octet has not arrived yet, or the first octet has already been overwritten in the 64-octet history ring.

A small packet state machine tracks the stream. It has three states: `ST_IDLE` (no packet seen since reset), `ST_RECV` (octets arriving) and `ST_DONE` (packet complete). There are four transitions. *open* takes `ST_IDLE` to `ST_RECV` on `pkt_start`. *restart* keeps `ST_RECV` in `ST_RECV` on `pkt_start`. *close* takes `ST_RECV` to `ST_DONE` on `pkt_end` when `pkt_start` is low. *reopen* takes `ST_DONE` to `ST_RECV` on `pkt_start`. A `pkt_start` clears the octet counter and the four loadable base registers. The requester loads those registers through a simple write port while the packet flows.

The request side is purely combinational from the state, the counter, the base registers and the ring. A sequencer can therefore re-present the same request every cycle until it is served.

Top module: `pkt_octet_window`

## Requirements
- R1: After reset the block is in `ST_IDLE`: for any request `rd_avail` is 0, `rd_stall` is 2'b01 (waiting) and `rd_word` is 0.
- R2: `req_base` 0 selects the value zero, which is the packet start. Codes 1 to 4 select loadable registers B1 to B4, written when `base_we` is high with `base_wsel` 0 to 3 naming B1 to B4. Codes 5 to 7 also select zero. `pkt_start` clears B1 to B4, and it wins over a write in the same cycle.
- R3: The start octet is the selected base value plus `req_off`. The served word holds octets start, start+1, start+2 and start+3, with octet start in bits 31:24 and octet start+3 in bits 7:0.
- R4: The served word is ANDed with a mask of (`req_bits`+1) ones at the low end: code 0 keeps bit 0 and code 31 keeps all 32 bits.
- R5: In `ST_RECV`, if octet start+3 has not yet arrived (start+3 >= octet count) and the start octet is still held, then `rd_avail` is 0, `rd_stall` is 2'b01 and `rd_word` is 0.
- R6: The ring keeps only the 64 most recent octets: octet n sits in slot n mod 64. In `ST_RECV`, when the count exceeds 64 and start < count-64, `rd_avail` is 0, `rd_stall` is 2'b10 (discarded) and `rd_word` is 0. This stall holds while the request is unchanged and the packet has not ended.
- R7: In `ST_DONE` every request is served (`rd_avail` 1, `rd_stall` 2'b00). Octets at or beyond the final count, and octets no longer held in the ring, read as zero. Octets offered after the end are ignored.
- R8: `pkt_start` restarts the count. An octet offered in the same cycle becomes octet 0. An octet offered together with `pkt_end` is counted as the last octet of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | First cycle of a new packet |
| pkt_end | input | 1 | Packet completed |
| oct_valid | input | 1 | `oct_data` carries an octet this cycle |
| oct_data | input | 8 | Incoming octet |
| base_we | input | 1 | Load a base register |
| base_wsel | input | 2 | Which of B1..B4 to load (0..3) |
| base_wval | input | CNT_W | Value to load |
| req_base | input | 3 | Base point of the request |
| req_off | input | 5 | Octet offset from the base point |
| req_bits | input | 5 | Length code; (code+1) low bits kept |
| rd_word | output | 32 | Masked word, zero when not available |
| rd_avail | output | 1 | Word may be used this cycle |
| rd_stall | output | 2 | 00 none, 01 waiting for octets, 10 octets discarded |

## Verification
A corrupted octet counter shows up at once as a wrong boundary between waiting, served and discarded outcomes. A slot written at the wrong ring index shows up as a wrong byte lane in `rd_word` in the cycle after the octet arrives. A packet state stuck in `ST_RECV` or `ST_IDLE` keeps `rd_avail` low after the end, and the next request exposes this. Sweeping every base code, every offset and a spread of length codes after each arriving octet moves every window boundary across every lane, so each such fault surfaces within one octet of its cause.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DONE = 2'd2
    } pkt_state_e;

    typedef enum logic [1:0] {
        STALL_NONE = 2'b00,
        STALL_WAIT = 2'b01,
        STALL_GONE = 2'b10
    } stall_e;

    localparam int unsigned LANES = 4;
endpackage

// File: rtl/pwx_ctrl.sv
module pwx_ctrl
    import pwx_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             pkt_end,
    input  logic             oct_valid,
    output pkt_state_e       st_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pkt_state_e       st_d;
    logic [CNT_W-1:0] cnt_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (pkt_start) st_d = ST_RECV;
            ST_RECV: begin
                if (pkt_start)    st_d = ST_RECV;
                else if (pkt_end) st_d = ST_DONE;
            end
            ST_DONE: if (pkt_start) st_d = ST_RECV;
            default: st_d = ST_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        wr_en  = oct_valid && (pkt_start || (st_q == ST_RECV && cnt_q != CNT_MAX));
        wr_idx = pkt_start ? '0 : cnt_q[IDX_W-1:0];
        if (pkt_start)
            cnt_d = oct_valid ? CNT_W'(1) : '0;
        else if (wr_en)
            cnt_d = cnt_q + CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RECV && oct_valid && !pkt_start && cnt_q != CNT_MAX)
        |=> (cnt_q == $past(cnt_q) + CNT_W'(1)))
        else $error("count did not advance on an accepted octet");

    p_start_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !oct_valid) |=> (cnt_q == '0 && st_q == ST_RECV))
        else $error("packet start did not restart the count");

    p_done_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !pkt_start) |=> (st_q == ST_DONE && $stable(cnt_q)))
        else $error("count moved after packet end");
endmodule

// File: rtl/pwx_ring.sv
module pwx_ring
    import pwx_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [7:0]                  wr_data,
    input  logic [LANES-1:0][IDX_W-1:0] rd_idx,
    output logic [LANES-1:0][7:0]       rd_byte
);
    logic [7:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_idx] <= wr_data;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rd_byte[k] = slot[rd_idx[k]];
    end
endmodule

// File: rtl/pwx_bases.sv
module pwx_bases #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned NUM_BASE = 4,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             base_we,
    input  logic [SEL_W-1:0] base_wsel,
    input  logic [CNT_W-1:0] base_wval,
    input  logic [2:0]       req_base,
    output logic [CNT_W-1:0] base_val
);
    logic [CNT_W-1:0] breg [NUM_BASE];

    for (genvar g = 0; g < NUM_BASE; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                breg[g] <= '0;
            else if (pkt_start)
                breg[g] <= '0;
            else if (base_we && base_wsel == SEL_W'(g))
                breg[g] <= base_wval;
        end

        p_base_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pkt_start |=> (breg[g] == '0))
            else $error("base register survived packet start");
    end

    // code 0 and codes above NUM_BASE select the packet start
    always_comb begin
        base_val = '0;
        for (int i = 0; i < NUM_BASE; i++) begin
            if (req_base == 3'(i + 1)) base_val = breg[i];
        end
    end
endmodule

// File: rtl/pwx_locate.sv
module pwx_locate
    import pwx_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  pkt_state_e                  st_q,
    input  logic [CNT_W-1:0]            cnt_q,
    input  logic [CNT_W-1:0]            base_val,
    input  logic [4:0]                  req_off,
    input  logic [4:0]                  req_bits,
    input  logic [LANES-1:0][7:0]       rd_byte,
    output logic [LANES-1:0][IDX_W-1:0] rd_idx,
    output logic [31:0]                 rd_word,
    output logic                        rd_avail,
    output stall_e                      rd_stall
);
    localparam int unsigned AW = CNT_W + 2;
    localparam logic [AW-1:0] WIN = AW'(DEPTH);

    logic [AW-1:0]          start, cnt_x;
    logic [LANES-1:0]       arrived, kept;
    logic [LANES-1:0][7:0]  lane;
    logic [31:0]            mask;

    assign start = AW'(base_val) + AW'(req_off);
    assign cnt_x = AW'(cnt_q);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [AW-1:0] idx;
        assign idx        = start + AW'(k);
        assign rd_idx[k]  = idx[IDX_W-1:0];
        assign arrived[k] = idx < cnt_x;
        assign kept[k]    = (cnt_x <= WIN) || (idx >= cnt_x - WIN);
        assign lane[k]    = (arrived[k] && kept[k]) ? rd_byte[k] : 8'h00;
    end

    assign mask = 32'hFFFF_FFFF >> (5'd31 - req_bits);

    always_comb begin
        rd_avail = 1'b0;
        rd_stall = STALL_WAIT;
        unique case (st_q)
            ST_IDLE: begin
                rd_avail = 1'b0;
                rd_stall = STALL_WAIT;
            end
            ST_RECV: begin
                if (!kept[0]) begin
                    rd_stall = STALL_GONE;
                end else if (!arrived[LANES-1]) begin
                    rd_stall = STALL_WAIT;
                end else begin
                    rd_avail = 1'b1;
                    rd_stall = STALL_NONE;
                end
            end
            ST_DONE: begin
                rd_avail = 1'b1;
                rd_stall = STALL_NONE;
            end
            default: begin
                rd_avail = 1'b0;
                rd_stall = STALL_WAIT;
            end
        endcase
        rd_word = rd_avail ? ({lane[0], lane[1], lane[2], lane[3]} & mask) : 32'h0;
    end

    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_word >> req_bits) >> 1) == 32'h0)
        else $error("bits above the length code are set");

    p_stall_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_avail |-> (rd_word == 32'h0 && rd_stall != STALL_NONE))
        else $error("stalled word not zero");
endmodule

// File: rtl/pkt_octet_window.sv
module pkt_octet_window
    import pwx_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned NUM_BASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             pkt_end,
    input  logic             oct_valid,
    input  logic [7:0]       oct_data,
    input  logic             base_we,
    input  logic [1:0]       base_wsel,
    input  logic [CNT_W-1:0] base_wval,
    input  logic [2:0]       req_base,
    input  logic [4:0]       req_off,
    input  logic [4:0]       req_bits,
    output logic [31:0]      rd_word,
    output logic             rd_avail,
    output logic [1:0]       rd_stall
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    pkt_state_e                  st_q;
    logic [CNT_W-1:0]            cnt_q;
    logic                        wr_en;
    logic [IDX_W-1:0]            wr_idx;
    logic [CNT_W-1:0]            base_val;
    logic [LANES-1:0][IDX_W-1:0] rd_idx;
    logic [LANES-1:0][7:0]       rd_byte;
    stall_e                      stall_w;

    pwx_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .oct_valid(oct_valid), .st_q(st_q), .cnt_q(cnt_q),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    pwx_ring #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ring (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(oct_data),
        .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    pwx_bases #(.CNT_W(CNT_W), .NUM_BASE(NUM_BASE), .SEL_W(2)) u_bases (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .base_we(base_we),
        .base_wsel(base_wsel), .base_wval(base_wval), .req_base(req_base),
        .base_val(base_val)
    );

    pwx_locate #(.CNT_W(CNT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_locate (
        .clk(clk), .rst_n(rst_n), .st_q(st_q), .cnt_q(cnt_q),
        .base_val(base_val), .req_off(req_off), .req_bits(req_bits),
        .rd_byte(rd_byte), .rd_idx(rd_idx), .rd_word(rd_word),
        .rd_avail(rd_avail), .rd_stall(stall_w)
    );

    assign rd_stall = stall_w;

    p_done_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |-> rd_avail)
        else $error("request not served after packet end");

    p_gone_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stall == STALL_GONE && !pkt_end && !pkt_start && !base_we)
        |=> (rd_stall == STALL_GONE || $changed(req_base) || $changed(req_off)))
        else $error("discarded stall released early");

    p_idle_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!rd_avail && rd_stall == STALL_WAIT))
        else $error("idle block served a word");
endmodule

// File: tb/pkt_octet_window_tb.sv
module pkt_octet_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0, pkt_end = 1'b0, oct_valid = 1'b0;
    logic [7:0]  oct_data = 8'h0;
    logic        base_we = 1'b0;
    logic [1:0]  base_wsel = 2'd0;
    logic [15:0] base_wval = 16'd0;
    logic [2:0]  req_base = 3'd0;
    logic [4:0]  req_off = 5'd0, req_bits = 5'd0;
    logic [31:0] rd_word;
    logic        rd_avail;
    logic [1:0]  rd_stall;

    int checks = 0;
    int errors = 0;
    int bvals [5];

    always #2 clk = ~clk;

    pkt_octet_window u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .oct_valid(oct_valid), .oct_data(oct_data), .base_we(base_we),
        .base_wsel(base_wsel), .base_wval(base_wval), .req_base(req_base),
        .req_off(req_off), .req_bits(req_bits), .rd_word(rd_word),
        .rd_avail(rd_avail), .rd_stall(rd_stall)
    );

    function automatic logic [7:0] dat(int n, int seed);
        return 8'(n * 7 + 3 + seed);
    endfunction

    // phase: 0 idle, 1 receiving, 2 done
    function automatic logic [34:0] model(int sel, int off, int bits, int cnt, int ph, int seed);
        int start;
        logic [31:0] w;
        logic av;
        logic [1:0] st;
        bit gone, pend;
        start = ((sel >= 1 && sel <= 4) ? bvals[sel] : 0) + off;
        gone  = (cnt > 64) && (start < cnt - 64);
        pend  = (start + 3) >= cnt;
        w = 32'h0;
        if (ph == 0) begin
            st = 2'b01; av = 1'b0;
        end else if (ph == 1 && gone) begin
            st = 2'b10; av = 1'b0;
        end else if (ph == 1 && pend) begin
            st = 2'b01; av = 1'b0;
        end else begin
            st = 2'b00; av = 1'b1;
            for (int k = 0; k < 4; k++) begin
                int idx;
                idx = start + k;
                if (idx < cnt && !(cnt > 64 && idx < cnt - 64))
                    w[31 - 8 * k -: 8] = dat(idx, seed);
            end
            w = w & (32'hFFFF_FFFF >> (31 - bits));
        end
        return {st, av, w};
    endfunction

    task automatic chk(string tag, logic [34:0] act, logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s stall/avail/word actual %b/%b/%h expected %b/%b/%h",
                     tag, act[34:33], act[32], act[31:0], exp[34:33], exp[32], exp[31:0]);
        end
    endtask

    task automatic sweep(int cnt, int ph, int seed);
        for (int sel = 0; sel < 8; sel++) begin
            for (int off = 0; off < 32; off++) begin
                logic [34:0] e;
                string tag;
                int bits;
                bits = (off * 3 + sel * 5 + cnt) % 32;
                req_base = 3'(sel);
                req_off  = 5'(off);
                req_bits = 5'(bits);
                #1;
                e = model(sel, off, bits, cnt, ph, seed);
                if (ph == 0)           tag = "R1";
                else if (ph == 2)      tag = "R7 R2 R3 R4";
                else if (e[34:33] == 2'b10) tag = "R6";
                else if (e[34:33] == 2'b01) tag = "R5";
                else                   tag = "R2 R3 R4 R8";
                chk(tag, {rd_stall, rd_avail, rd_word}, e);
            end
        end
    endtask

    task automatic push(logic [7:0] d, logic st, logic en);
        @(negedge clk);
        oct_valid = 1'b1; oct_data = d; pkt_start = st; pkt_end = en;
        @(negedge clk);
        oct_valid = 1'b0; pkt_start = 1'b0; pkt_end = 1'b0;
    endtask

    task automatic load(int sel, int val);
        @(negedge clk);
        base_we = 1'b1; base_wsel = 2'(sel - 1); base_wval = 16'(val);
        @(negedge clk);
        base_we = 1'b0;
        bvals[sel] = val;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) bvals[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        sweep(0, 0, 0);

        // packet A: 100 octets, bases loaded mid-stream
        push(dat(0, 0), 1'b1, 1'b0);
        load(1, 2);
        load(2, 20);
        load(3, 45);
        load(4, 85);
        sweep(1, 1, 0);
        for (int n = 1; n < 100; n++) begin
            push(dat(n, 0), 1'b0, n == 99);
            sweep(n + 1, (n == 99) ? 2 : 1, 0);
        end
        // R7: octets offered after the end are ignored
        push(8'hEE, 1'b0, 1'b0);
        push(8'hDD, 1'b0, 1'b0);
        sweep(100, 2, 0);

        // packet B: start with a same-cycle base write (R2, R8)
        @(negedge clk);
        oct_valid = 1'b1; oct_data = dat(0, 11); pkt_start = 1'b1;
        base_we = 1'b1; base_wsel = 2'd0; base_wval = 16'd50;
        @(negedge clk);
        oct_valid = 1'b0; pkt_start = 1'b0; base_we = 1'b0;
        for (int i = 0; i < 5; i++) bvals[i] = 0;
        sweep(1, 1, 11);
        for (int n = 1; n < 8; n++) begin
            push(dat(n, 11), 1'b0, 1'b0);
            sweep(n + 1, 1, 11);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule